// File: doc/BRIEF.md
# Greedy Garbage Collection Controller

This block reclaims space in a page-mapped flash translation layer. It watches the number of free blocks. When that number drops below a low-water mark, it takes ownership of the die and reclaims blocks one at a time. For each reclaim it picks the block holding the fewest valid pages, which is also the block holding the most stale pages. It moves every live page of that block into the open block, erases the block and hands its number back to the free pool. It keeps reclaiming until the free count reaches a higher target, so it does not flap around a single threshold.

The controller reads per-block valid counts and free flags through one read port, and per-page validity through a second read port. Both ports return data in the same cycle. Relocation and erase requests leave on a single command channel that uses a valid/ready handshake. The controller never reaches the media itself, so media timing belongs to whoever accepts the commands. A free-pool push strobe reports each reclaimed block. Host requests to the die are granted only while no collection is running.

Top module: `gc_ctrl`

## Requirements
- R1: A collection starts (busy rises on the next clock edge) when the controller is idle and `free_cnt` is strictly below LOW_TH. A count equal to LOW_TH, or any value between LOW_TH and HIGH_TH, never starts one.
- R2: After each reclaimed block the controller re-examines `free_cnt`. It selects another victim while the count is below HIGH_TH and drops busy once the count is at or above HIGH_TH.
- R3: The victim is the block with the smallest valid-page count among eligible blocks. On a tie, the lowest block number wins.
- R4: The current open block (`open_blk`) and every block flagged free on `vc_free` are never chosen as victims.
- R5: For the victim, one copy command (`cmd_op` = 0) is issued per valid page. The commands name the victim in `cmd_blk` and the page in `cmd_page`, go out in ascending page order, and all precede the erase. Invalid pages produce no command.
- R6: Exactly one erase command (`cmd_op` = 1, `cmd_page` = 0) follows the copies of each victim. One cycle after that erase is accepted, `push_valid` pulses for one cycle with `push_blk` equal to the victim.
- R7: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. While it waits it holds its operation, block and page unchanged, and the next command appears only after acceptance.
- R8: `busy` is high from the first scan cycle until the controller returns to idle. `host_gnt` equals `host_req` while not busy and is low while busy.
- R9: After reset, `busy`, `cmd_valid` and `push_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| free_cnt | input | $clog2(NBLK+1) | Current number of blocks in the free pool |
| open_blk | input | $clog2(NBLK) | Block currently open for writes |
| host_req | input | 1 | Host wants the die |
| host_gnt | output | 1 | Host access granted |
| busy | output | 1 | Collection owns the die |
| vc_addr | output | $clog2(NBLK) | Block addressed on the count port |
| vc_count | input | $clog2(PAGES+1) | Valid pages in block `vc_addr` |
| vc_free | input | 1 | Block `vc_addr` is in the free pool |
| bm_blk | output | $clog2(NBLK) | Block addressed on the bitmap port |
| bm_page | output | $clog2(PAGES) | Page addressed on the bitmap port |
| bm_valid | input | 1 | Addressed page holds live data |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted this cycle |
| cmd_op | output | 1 | 0 = copy page, 1 = erase block |
| cmd_blk | output | $clog2(NBLK) | Source block of copy, or block to erase |
| cmd_page | output | $clog2(PAGES) | Page to copy (0 for erase) |
| push_valid | output | 1 | Reclaimed block returned to free pool |
| push_blk | output | $clog2(NBLK) | Number of the returned block |

## Verification
The bench builds scenarios in which the lowest count sits in the open block and two blocks tie for the minimum. A design that ignores the exclusion would pick the open block, and one that breaks ties upward would pick the higher block; either way the command stream diverges. It also plants a victim with no valid pages and victims with every page valid. A design that emits a copy for an empty block, or stops the copies one page early or one page late, fails the stream comparison. The threshold band is probed by lowering the free count to exactly the low mark, which must not start a collection, and then one below it. A design that compared with less-or-equal, or that stopped at the low mark instead of the high one, would show the wrong busy level or the wrong number of pushes. The ready input is stalled at random so that a command which changes or advances before acceptance shows up as a mismatch.

// File: rtl/gc_pkg.sv
// Shared types for the garbage collection controller.
// Assumes: nothing beyond SystemVerilog enums.
package gc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCAN,
        PH_RELOC,
        PH_PUSH,
        PH_CHECK
    } gc_phase_t;

    typedef enum logic [1:0] {
        RL_IDLE,
        RL_PROBE,
        RL_ISSUE,
        RL_ERASE
    } reloc_state_t;

    localparam logic OP_COPY  = 1'b0;
    localparam logic OP_ERASE = 1'b1;
endpackage

// File: rtl/gc_victim_scan.sv
// Sequential greedy victim search: visits one block per cycle on the
// count port and keeps the eligible block with the lowest valid count.
// A strict less-than keeps the earliest block on ties.
// Assumes: count port returns data in the same cycle; inputs stay
// stable during the scan.
module gc_victim_scan #(
    parameter int NBLK  = 16,
    parameter int PAGES = 8,
    localparam int BW = $clog2(NBLK),
    localparam int CW = $clog2(PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] open_blk,
    output logic [BW-1:0] vc_addr,
    input  logic [CW-1:0] vc_count,
    input  logic          vc_free,
    output logic          done,
    output logic          found,
    output logic [BW-1:0] victim
);
    localparam logic [BW-1:0] LAST_BLK = BW'(NBLK - 1);

    logic          active;
    logic [BW-1:0] idx;
    logic          have;
    logic [CW-1:0] best_cnt;
    logic [BW-1:0] best_blk;
    logic          done_q;
    logic          eligible;
    logic          better;

    // Eligibility and improvement test for the block under the pointer.
    always_comb begin
        eligible = !vc_free && (idx != open_blk);
        better   = eligible && (!have || (vc_count < best_cnt));
    end

    // Walk the block range and track the best candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            have     <= 1'b0;
            best_cnt <= '0;
            best_blk <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active <= 1'b1;
                idx    <= '0;
                have   <= 1'b0;
            end else if (active) begin
                if (better) begin
                    have     <= 1'b1;
                    best_cnt <= vc_count;
                    best_blk <= idx;
                end
                if (idx == LAST_BLK) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign vc_addr = idx;
    assign done    = done_q;
    assign found   = have;
    assign victim  = best_blk;
endmodule

// File: rtl/gc_reloc_seq.sv
// Relocation sequencer: probes each page of the victim on the bitmap
// port, issues one copy per live page, then one erase.
// Assumes: the victim's bitmap stays stable until its erase is accepted.
module gc_reloc_seq
    import gc_pkg::*;
#(
    parameter int NBLK  = 16,
    parameter int PAGES = 8,
    localparam int BW = $clog2(NBLK),
    localparam int PW = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] victim,
    output logic [BW-1:0] bm_blk,
    output logic [PW-1:0] bm_page,
    input  logic          bm_valid,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_op,
    output logic [BW-1:0] cmd_blk,
    output logic [PW-1:0] cmd_page,
    output logic          done
);
    localparam logic [PW-1:0] LAST_PG = PW'(PAGES - 1);

    reloc_state_t  st;
    logic [PW-1:0] pg;
    logic [BW-1:0] blk;
    logic          last;

    assign last = (pg == LAST_PG);

    // Page walk: probe, issue copy if live, erase after the last page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RL_IDLE;
            pg  <= '0;
            blk <= '0;
        end else begin
            case (st)
                RL_IDLE: if (start) begin
                    blk <= victim;
                    pg  <= '0;
                    st  <= RL_PROBE;
                end
                RL_PROBE: begin
                    if (bm_valid)  st <= RL_ISSUE;
                    else if (last) st <= RL_ERASE;
                    else           pg <= pg + 1'b1;
                end
                RL_ISSUE: if (cmd_ready) begin
                    if (last) st <= RL_ERASE;
                    else begin
                        pg <= pg + 1'b1;
                        st <= RL_PROBE;
                    end
                end
                RL_ERASE: if (cmd_ready) st <= RL_IDLE;
                default: st <= RL_IDLE;
            endcase
        end
    end

    // Command and bitmap port drive from the walk state.
    always_comb begin
        bm_blk    = blk;
        bm_page   = pg;
        cmd_valid = (st == RL_ISSUE) || (st == RL_ERASE);
        cmd_op    = (st == RL_ERASE) ? OP_ERASE : OP_COPY;
        cmd_blk   = blk;
        cmd_page  = (st == RL_ERASE) ? '0 : pg;
        done      = (st == RL_ERASE) && cmd_ready;
    end

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_op) && $stable(cmd_blk) && $stable(cmd_page)));

    // R5
    copy_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_COPY) |-> bm_valid);
endmodule

// File: rtl/gc_ctrl.sv
// Greedy garbage collection controller top. Phase machine: start below
// LOW_TH, scan for a victim, relocate and erase it, push it to the free
// pool, then stop once free_cnt reaches HIGH_TH. Holds the die while busy.
// Assumes: free_cnt reflects a push by the cycle after push_valid.
module gc_ctrl
    import gc_pkg::*;
#(
    parameter int NBLK    = 16,
    parameter int PAGES   = 8,
    parameter int LOW_TH  = 3,
    parameter int HIGH_TH = 5,
    localparam int BW = $clog2(NBLK),
    localparam int PW = $clog2(PAGES),
    localparam int CW = $clog2(PAGES + 1),
    localparam int FW = $clog2(NBLK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] free_cnt,
    input  logic [BW-1:0] open_blk,
    input  logic          host_req,
    output logic          host_gnt,
    output logic          busy,
    output logic [BW-1:0] vc_addr,
    input  logic [CW-1:0] vc_count,
    input  logic          vc_free,
    output logic [BW-1:0] bm_blk,
    output logic [PW-1:0] bm_page,
    input  logic          bm_valid,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_op,
    output logic [BW-1:0] cmd_blk,
    output logic [PW-1:0] cmd_page,
    output logic          push_valid,
    output logic [BW-1:0] push_blk
);
    localparam logic [FW-1:0] LOW_V  = FW'(LOW_TH);
    localparam logic [FW-1:0] HIGH_V = FW'(HIGH_TH);

    gc_phase_t     phase;
    logic          scan_start;
    logic          scan_done;
    logic          scan_found;
    logic [BW-1:0] scan_victim;
    logic          rel_start;
    logic          rel_done;

    // Start pulses for the scanner and the relocator.
    always_comb begin
        scan_start = ((phase == PH_IDLE)  && (free_cnt < LOW_V)) ||
                     ((phase == PH_CHECK) && (free_cnt < HIGH_V));
        rel_start  = (phase == PH_SCAN) && scan_done && scan_found;
    end

    // Phase sequencing with hysteresis between LOW_TH and HIGH_TH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:  if (scan_start) phase <= PH_SCAN;
                PH_SCAN:  if (scan_done) phase <= scan_found ? PH_RELOC : PH_IDLE;
                PH_RELOC: if (rel_done) phase <= PH_PUSH;
                PH_PUSH:  phase <= PH_CHECK;
                PH_CHECK: phase <= scan_start ? PH_SCAN : PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    gc_victim_scan #(.NBLK(NBLK), .PAGES(PAGES)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (scan_start),
        .open_blk (open_blk),
        .vc_addr  (vc_addr),
        .vc_count (vc_count),
        .vc_free  (vc_free),
        .done     (scan_done),
        .found    (scan_found),
        .victim   (scan_victim)
    );

    gc_reloc_seq #(.NBLK(NBLK), .PAGES(PAGES)) u_reloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rel_start),
        .victim    (scan_victim),
        .bm_blk    (bm_blk),
        .bm_page   (bm_page),
        .bm_valid  (bm_valid),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_blk   (cmd_blk),
        .cmd_page  (cmd_page),
        .done      (rel_done)
    );

    // Die ownership, host gating and free-pool return.
    always_comb begin
        busy       = (phase != PH_IDLE);
        host_gnt   = host_req && !busy;
        push_valid = (phase == PH_PUSH);
        push_blk   = scan_victim;
    end

    // R1
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && free_cnt < LOW_V) |=> busy);

    // R2
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(free_cnt) >= HIGH_V || $past(scan_done && !scan_found)));

    // R6
    push_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(cmd_valid && cmd_ready && cmd_op == OP_ERASE && cmd_blk == push_blk));

    // R4
    erase_not_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERASE) |-> (cmd_blk != open_blk));
endmodule

// File: tb/sim_gc_ctrl.sv
// Bench for gc_ctrl: directed corner scenarios plus seeded random ones,
// with an independent greedy model giving the expected command stream.
module sim_gc_ctrl;
    localparam int NB = 16;
    localparam int NP = 8;
    localparam int LOW = 3;
    localparam int HIGH = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    free_n = 5'd16;
    logic [3:0]    open_b = 4'd0;
    logic          host_req = 1'b0;
    logic          host_gnt, busy;
    logic [3:0]    vc_addr;
    logic [3:0]    vc_count;
    logic          vc_free;
    logic [3:0]    bm_blk;
    logic [2:0]    bm_page;
    logic          bm_valid;
    logic          cmd_valid, cmd_op;
    logic          cmd_ready = 1'b0;
    logic [3:0]    cmd_blk;
    logic [2:0]    cmd_page;
    logic          push_valid;
    logic [3:0]    push_blk;

    logic [NP-1:0] bmap [NB];
    logic [NB-1:0] isfree = '1;

    int checks = 0;
    int fails = 0;
    int rdy_mode = 0;

    int exp_op [256];
    int exp_blk [256];
    int exp_pg [256];
    int exp_push [32];
    int n_exp, n_push, k_cmd, k_push;

    always #10 clk = ~clk;

    assign vc_count = 4'($countones(bmap[vc_addr]));
    assign vc_free  = isfree[vc_addr];
    assign bm_valid = bmap[bm_blk][bm_page];

    gc_ctrl #(.NBLK(NB), .PAGES(NP), .LOW_TH(LOW), .HIGH_TH(HIGH)) u0 (
        .clk(clk), .rst_n(rst_n), .free_cnt(free_n), .open_blk(open_b),
        .host_req(host_req), .host_gnt(host_gnt), .busy(busy),
        .vc_addr(vc_addr), .vc_count(vc_count), .vc_free(vc_free),
        .bm_blk(bm_blk), .bm_page(bm_page), .bm_valid(bm_valid),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_page(cmd_page),
        .push_valid(push_valid), .push_blk(push_blk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Greedy reference model producing the expected stream.
    task automatic compute_expected();
        logic [NB-1:0] fr = isfree;
        int f = free_n;
        n_exp = 0;
        n_push = 0;
        if (f >= LOW) return;
        while (f < HIGH) begin
            int best = -1;
            int bestc = 0;
            for (int b = 0; b < NB; b++) begin
                int c = $countones(bmap[b]);
                if (!fr[b] && b != int'(open_b) && (best < 0 || c < bestc)) begin
                    best = b;
                    bestc = c;
                end
            end
            if (best < 0) break;
            for (int p = 0; p < NP; p++) begin
                if (bmap[best][p]) begin
                    exp_op[n_exp] = 0; exp_blk[n_exp] = best; exp_pg[n_exp] = p;
                    n_exp++;
                end
            end
            exp_op[n_exp] = 1; exp_blk[n_exp] = best; exp_pg[n_exp] = 0;
            n_exp++;
            exp_push[n_push] = best;
            n_push++;
            fr[best] = 1'b1;
            f++;
        end
    endtask

    // One cycle: drive inputs at the falling edge, then observe.
    task automatic step();
        @(negedge clk);
        cmd_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
        host_req  = $urandom % 2;
        #1;
        // R8
        check(host_gnt == (host_req && !busy), "R8 host grant", int'(host_gnt), int'(host_req && !busy));
        if (cmd_valid && cmd_ready) begin
            if (k_cmd >= n_exp) begin
                check(1'b0, "R5 extra command", int'(cmd_blk), -1);
            end else begin
                check(int'(cmd_op) == exp_op[k_cmd], "R6 command op", int'(cmd_op), exp_op[k_cmd]);
                check(int'(cmd_blk) == exp_blk[k_cmd], "R3 victim block", int'(cmd_blk), exp_blk[k_cmd]);
                check(int'(cmd_page) == exp_pg[k_cmd], "R5 copy page", int'(cmd_page), exp_pg[k_cmd]);
            end
            k_cmd++;
        end
        if (push_valid) begin
            if (k_push < n_push)
                check(int'(push_blk) == exp_push[k_push], "R6 pushed block", int'(push_blk), exp_push[k_push]);
            else
                check(1'b0, "R2 extra push", int'(push_blk), -1);
            k_push++;
            isfree[push_blk] = 1'b1;
            bmap[push_blk] = '0;
            free_n = free_n + 1'b1;
        end
    endtask

    // Run one collection to completion and compare totals.
    task automatic run_gc(input string name);
        bit seen = 0;
        bit ended = 0;
        compute_expected();
        k_cmd = 0;
        k_push = 0;
        for (int i = 0; i < 4000; i++) begin
            step();
            if (busy) seen = 1;
            else if (seen) begin
                ended = 1;
                break;
            end
        end
        check(ended, "R2 collection ended", int'(ended), 1);
        check(k_cmd == n_exp, "R5 command count", k_cmd, n_exp);
        check(k_push == n_push, "R2 push count", k_push, n_push);
        check(int'(free_n) >= HIGH, "R2 final free count", int'(free_n), HIGH);
        $display("scenario %s: %0d commands, %0d blocks reclaimed", name, k_cmd, k_push);
    endtask

    task automatic clear_all();
        for (int b = 0; b < NB; b++) bmap[b] = '0;
        isfree = '0;
    endtask

    task automatic random_scene();
        int nf = $urandom % 3;
        int dens = $urandom % 3;
        clear_all();
        open_b = 4'($urandom % NB);
        for (int b = 0; b < NB; b++) begin
            logic [NP-1:0] r = NP'($urandom);
            if (dens == 0) r = r & NP'($urandom);
            else if (dens == 2) r = r | NP'($urandom);
            bmap[b] = r;
        end
        for (int n = 0; n < nf; ) begin
            int b = $urandom % NB;
            if (!isfree[b] && b != int'(open_b)) begin
                isfree[b] = 1'b1;
                bmap[b] = '0;
                n++;
            end
        end
        free_n = 5'(nf);
        rdy_mode = $urandom % 2;
    endtask

    task automatic take_free(input int n);
        int taken = 0;
        for (int b = 0; b < NB && taken < n; b++) begin
            if (isfree[b] && b != int'(open_b)) begin
                isfree[b] = 1'b0;
                free_n = free_n - 1'b1;
                taken++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < NB; b++) bmap[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R9
        check(!busy, "R9 busy after reset", int'(busy), 0);
        check(!cmd_valid, "R9 cmd_valid after reset", int'(cmd_valid), 0);
        check(!push_valid, "R9 push_valid after reset", int'(push_valid), 0);

        // Directed: open block holds the minimum (R4), empty victim, tie (R3).
        @(negedge clk);
        clear_all();
        for (int b = 0; b < NB; b++) bmap[b] = '1;
        open_b = 4'd2;  bmap[2] = '0;
        bmap[12] = '0;
        bmap[5] = 8'b0010_0000;
        bmap[9] = 8'b0000_0100;
        isfree[0] = 1'b1; bmap[0] = '0;
        isfree[1] = 1'b1; bmap[1] = '0;
        free_n = 5'd2;
        rdy_mode = 1;
        run_gc("tie_open_empty");

        // R1 hysteresis: free count equal to LOW must not start.
        begin
            bit rose = 0;
            @(negedge clk);
            take_free(HIGH - LOW);
            for (int i = 0; i < 30; i++) begin
                step();
                if (busy) rose = 1;
            end
            check(!rose, "R1 no start at low mark", int'(rose), 0);
            @(negedge clk);
            take_free(1);
            run_gc("one_below_low");
        end

        // Directed: every candidate full, ready always high.
        @(negedge clk);
        clear_all();
        for (int b = 0; b < NB; b++) bmap[b] = '1;
        open_b = 4'd15;
        isfree[3] = 1'b1; bmap[3] = '0;
        free_n = 5'd1;
        rdy_mode = 0;
        run_gc("all_full");

        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            random_scene();
            run_gc("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 180000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule